// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block sequences the work of a single DMA channel. It sits between the channel's configuration and a byte-moving transfer engine, and it decides which transfers run and in what order. It has two modes. In direct mode a start pulse launches exactly one transfer, taken from the latched size, source and destination inputs. In list mode the start pulse latches a 64-bit list pointer, and the walker then reads descriptors from memory through a one-word read request/response port.

A descriptor is six 32-bit words. Word 0 is control, word 1 is the byte count, words 2 and 3 are the low and high halves of the source address, and words 4 and 5 are the low and high halves of the destination address. Bit 2 of the control word tells a link element from a data element. A data element is passed to the transfer engine as a size/source/destination triple. A link element moves no data. Its source address field names the next descriptor, which lets a chain jump over memory. If a link element also has bit 1 (toggle) set, the whole chain ends.

Bits 3 and 4 of a data element ask for a local and a remote interrupt pulse when that element's transfer completes. In direct mode the channel-level enable inputs make the same choice instead. The walker signals done on a clean finish. It signals abort on a transfer error or a stop request, and after an abort it fetches and launches nothing more.

The state machine has six states:
- W_IDLE: waits for start.
- W_RD_REQ: issues one word read.
- W_RD_WAIT: waits for that word's response.
- W_DECODE: classifies the fetched element.
- W_LAUNCH: pulses the transfer start.
- W_XWAIT: waits for the engine to finish.

Its transitions are:
- W_IDLE to W_RD_REQ on start in list mode, or to W_LAUNCH on start in direct mode.
- W_RD_REQ to W_RD_WAIT.
- W_RD_WAIT to W_RD_REQ while words remain, or to W_DECODE on the sixth response.
- W_DECODE to W_LAUNCH for a data element, to W_RD_REQ for a plain link, or to W_IDLE for a terminating link.
- W_LAUNCH to W_XWAIT.
- W_XWAIT to W_RD_REQ after a list transfer, to W_IDLE after a direct transfer, or to W_IDLE on error.
- Any busy state to W_IDLE on stop.

Top module: `dma_desc_walker`

## Requirements
- R1: After reset the walker is idle: busy, rd_req, xfer_start, done, abort, irq_local and irq_remote are all 0.
- R2: In direct mode (cfg_list_mode=0), start launches exactly one transfer with the latched cfg_size, cfg_src and cfg_dst, issues no memory read, and pulses done in the cycle the engine reports xfer_done.
- R3: In direct mode, transfer completion pulses irq_local when cfg_lie_en was 1 at start, and pulses irq_remote when cfg_rie_en was 1 at start.
- R4: In list mode the six words of a descriptor are read at descriptor address +0, +4, +8, +12, +16 and +20, in that order. At most one read is outstanding at a time, and the first descriptor address is cfg_list_ptr.
- R5: A data element (control bit 2 = 0) launches a transfer with size = word 1, source = {word 3, word 2} and destination = {word 5, word 4}. After that transfer completes, the next descriptor is fetched from the current descriptor address plus 24.
- R6: A link element (control bit 2 = 1, bit 1 = 0) launches no transfer, and the next descriptor is fetched from {word 3, word 2}.
- R7: A link element with control bit 1 = 1 ends the chain. The walker pulses done, returns to idle, and issues no further read or transfer.
- R8: In list mode, a data element's control bit 3 pulses irq_local and its bit 4 pulses irq_remote in the cycle its transfer completes. The channel enable inputs have no effect in this mode.
- R9: If xfer_err is reported while a transfer is outstanding, the walker pulses abort (not done), goes idle, and reads nothing more.
- R10: stop_req while busy pulses abort in the same cycle and returns the walker to idle. No read request or transfer start is issued in that cycle or afterwards.
- R11: A start pulse while busy is ignored, and control bit 0 (cycle bit) has no effect on the walk.
- R12: done and abort are single-cycle pulses that never occur together, and busy falls only in a cycle that follows done or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only when idle |
| stop_req | input | 1 | Stop request; aborts a busy walk |
| cfg_list_mode | input | 1 | 1 selects list mode, 0 direct mode |
| cfg_lie_en | input | 1 | Direct-mode local interrupt enable |
| cfg_rie_en | input | 1 | Direct-mode remote interrupt enable |
| cfg_size | input | 32 | Direct-mode byte count |
| cfg_src | input | 64 | Direct-mode source address |
| cfg_dst | input | 64 | Direct-mode destination address |
| cfg_list_ptr | input | 64 | Address of the first descriptor |
| rd_req | output | 1 | Word read request, one cycle |
| rd_addr | output | 64 | Byte address of the requested word |
| rd_vld | input | 1 | Read response valid |
| rd_data | input | 32 | Read response word |
| xfer_start | output | 1 | Transfer launch pulse |
| xfer_size | output | 32 | Transfer byte count |
| xfer_src | output | 64 | Transfer source address |
| xfer_dst | output | 64 | Transfer destination address |
| xfer_done | input | 1 | Engine reports transfer complete |
| xfer_err | input | 1 | Engine reports transfer error |
| busy | output | 1 | Walker not idle |
| done | output | 1 | Walk finished cleanly, one cycle |
| abort | output | 1 | Walk aborted, one cycle |
| irq_local | output | 1 | Local interrupt request pulse |
| irq_remote | output | 1 | Remote interrupt request pulse |

## Verification
The bound checker checks the cycle-level rules on every cycle:
- no second read while one is outstanding;
- done and abort mutually exclusive;
- busy dropping only after one of them;
- stop turning into an immediate abort;
- silence on both request ports after an abort;
- single-cycle transfer launches;
- interrupt pulses coinciding with engine completion.

The values the walker produces can only be shown by the directed scenarios that model memory and the engine:
- the exact address sequence across link jumps and the +24 advance;
- the triples handed to the engine;
- chain termination;
- mode-dependent interrupt selection;
- the ignored start and cycle bit.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;

    // Descriptor word slots; the walker decodes these positions
    localparam int SLOT_CTRL   = 0;
    localparam int SLOT_SIZE   = 1;
    localparam int SLOT_SRC_LO = 2;
    localparam int SLOT_SRC_HI = 3;
    localparam int SLOT_DST_LO = 4;
    localparam int SLOT_DST_HI = 5;
    localparam int MIN_WORDS   = 6;

    // Control word bit positions
    localparam int CB_CYCLE  = 0;
    localparam int CB_TOGGLE = 1;
    localparam int CB_LINK   = 2;
    localparam int CB_LIE    = 3;
    localparam int CB_RIE    = 4;

    typedef enum logic [2:0] {
        W_IDLE    = 3'd0,
        W_RD_REQ  = 3'd1,
        W_RD_WAIT = 3'd2,
        W_DECODE  = 3'd3,
        W_LAUNCH  = 3'd4,
        W_XWAIT   = 3'd5
    } wstate_t;

endpackage

// File: rtl/dwalk_desc_regs.sv
module dwalk_desc_regs #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 6,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [NWORDS-1:0][WORD_W-1:0] words
);

    for (genvar g = 0; g < NWORDS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                words[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/dwalk_ptr.sv
module dwalk_ptr #(
    parameter int ADDR_W = 64,
    parameter int WORD_W = 32,
    parameter int NWORDS = 6,
    localparam int IDX_W = $clog2(NWORDS),
    localparam int BYTES = WORD_W / 8,
    localparam int STEP  = NWORDS * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              link_en,
    input  logic [ADDR_W-1:0] link_val,
    input  logic              adv_en,
    input  logic [IDX_W-1:0]  word_idx,
    output logic [ADDR_W-1:0] word_addr
);

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_en) begin
            base_q <= load_val;
        end else if (link_en) begin
            base_q <= link_val;
        end else if (adv_en) begin
            base_q <= base_q + ADDR_W'(STEP);
        end
    end

    assign word_addr = base_q + (ADDR_W'(word_idx) * ADDR_W'(BYTES));

endmodule

// File: rtl/dwalk_fsm.sv
module dwalk_fsm
    import dwalk_pkg::*;
#(
    parameter int NWORDS = 6,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop_req,
    input  logic             mode_list_in,
    input  logic             mode_list_q,
    input  logic             rd_vld,
    input  logic             xfer_done,
    input  logic             xfer_err,
    input  logic             is_link,
    input  logic             is_toggle,
    output logic [IDX_W-1:0] word_idx,
    output logic             accept,
    output logic             cap_en,
    output logic             link_en,
    output logic             adv_en,
    output logic             rd_req,
    output logic             xfer_start,
    output logic             xfer_ok,
    output logic             busy,
    output logic             done,
    output logic             abort
);

    wstate_t state_q, state_d;
    logic    last_word;

    assign last_word = (word_idx == IDX_W'(NWORDS - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:    if (start) state_d = mode_list_in ? W_RD_REQ : W_LAUNCH;
            W_RD_REQ:  state_d = W_RD_WAIT;
            W_RD_WAIT: if (rd_vld) state_d = last_word ? W_DECODE : W_RD_REQ;
            W_DECODE:  begin
                if (is_link) state_d = is_toggle ? W_IDLE : W_RD_REQ;
                else         state_d = W_LAUNCH;
            end
            W_LAUNCH:  state_d = W_XWAIT;
            W_XWAIT:   begin
                if (xfer_err)       state_d = W_IDLE;
                else if (xfer_done) state_d = mode_list_q ? W_RD_REQ : W_IDLE;
            end
            default:   state_d = W_IDLE;
        endcase
        if (stop_req && (state_q != W_IDLE)) state_d = W_IDLE;
    end

    // State register and word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= W_IDLE;
            word_idx <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != W_RD_REQ && state_q != W_RD_WAIT) begin
                word_idx <= '0;
            end else if (state_q == W_RD_WAIT && rd_vld && !last_word) begin
                word_idx <= word_idx + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != W_IDLE);
        accept     = (state_q == W_IDLE) && start;
        rd_req     = (state_q == W_RD_REQ) && !stop_req;
        cap_en     = (state_q == W_RD_WAIT) && rd_vld && !stop_req;
        xfer_start = (state_q == W_LAUNCH) && !stop_req;
        xfer_ok    = (state_q == W_XWAIT) && xfer_done && !xfer_err && !stop_req;
        link_en    = (state_q == W_DECODE) && is_link && !is_toggle && !stop_req;
        adv_en     = xfer_ok && mode_list_q;
        done       = ((state_q == W_DECODE) && is_link && is_toggle && !stop_req)
                   || (xfer_ok && !mode_list_q);
        abort      = (busy && stop_req)
                   || ((state_q == W_XWAIT) && xfer_err);
    end

endmodule

// File: rtl/dma_desc_walker.sv
module dma_desc_walker
    import dwalk_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = MIN_WORDS,
    localparam int ADDR_W = 2 * WORD_W,
    localparam int IDX_W  = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop_req,
    input  logic              cfg_list_mode,
    input  logic              cfg_lie_en,
    input  logic              cfg_rie_en,
    input  logic [WORD_W-1:0] cfg_size,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [ADDR_W-1:0] cfg_list_ptr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_vld,
    input  logic [WORD_W-1:0] rd_data,
    output logic              xfer_start,
    output logic [WORD_W-1:0] xfer_size,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    input  logic              xfer_done,
    input  logic              xfer_err,
    output logic              busy,
    output logic              done,
    output logic              abort,
    output logic              irq_local,
    output logic              irq_remote
);

    logic [NWORDS-1:0][WORD_W-1:0] words;
    logic [IDX_W-1:0]  word_idx;
    logic              accept, cap_en, link_en, adv_en, xfer_ok;
    logic              list_q, lie_q, rie_q;
    logic [WORD_W-1:0] dsize_q;
    logic [ADDR_W-1:0] dsrc_q, ddst_q;
    logic [WORD_W-1:0] ctrl_w;
    logic [ADDR_W-1:0] el_src, el_dst;

    assign ctrl_w = words[SLOT_CTRL];
    assign el_src = {words[SLOT_SRC_HI], words[SLOT_SRC_LO]};
    assign el_dst = {words[SLOT_DST_HI], words[SLOT_DST_LO]};

    // Configuration latched at an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            list_q  <= 1'b0;
            lie_q   <= 1'b0;
            rie_q   <= 1'b0;
            dsize_q <= '0;
            dsrc_q  <= '0;
            ddst_q  <= '0;
        end else if (accept) begin
            list_q  <= cfg_list_mode;
            lie_q   <= cfg_lie_en;
            rie_q   <= cfg_rie_en;
            dsize_q <= cfg_size;
            dsrc_q  <= cfg_src;
            ddst_q  <= cfg_dst;
        end
    end

    dwalk_fsm #(.NWORDS(NWORDS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .stop_req     (stop_req),
        .mode_list_in (cfg_list_mode),
        .mode_list_q  (list_q),
        .rd_vld       (rd_vld),
        .xfer_done    (xfer_done),
        .xfer_err     (xfer_err),
        .is_link      (ctrl_w[CB_LINK]),
        .is_toggle    (ctrl_w[CB_TOGGLE]),
        .word_idx     (word_idx),
        .accept       (accept),
        .cap_en       (cap_en),
        .link_en      (link_en),
        .adv_en       (adv_en),
        .rd_req       (rd_req),
        .xfer_start   (xfer_start),
        .xfer_ok      (xfer_ok),
        .busy         (busy),
        .done         (done),
        .abort        (abort)
    );

    dwalk_desc_regs #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cap_en),
        .wr_idx  (word_idx),
        .wr_data (rd_data),
        .words   (words)
    );

    dwalk_ptr #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NWORDS(NWORDS)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (accept && cfg_list_mode),
        .load_val  (cfg_list_ptr),
        .link_en   (link_en),
        .link_val  (el_src),
        .adv_en    (adv_en),
        .word_idx  (word_idx),
        .word_addr (rd_addr)
    );

    // Transfer triple and interrupt selection by mode
    always_comb begin
        if (list_q) begin
            xfer_size  = words[SLOT_SIZE];
            xfer_src   = el_src;
            xfer_dst   = el_dst;
            irq_local  = xfer_ok && ctrl_w[CB_LIE];
            irq_remote = xfer_ok && ctrl_w[CB_RIE];
        end else begin
            xfer_size  = dsize_q;
            xfer_src   = dsrc_q;
            xfer_dst   = ddst_q;
            irq_local  = xfer_ok && lie_q;
            irq_remote = xfer_ok && rie_q;
        end
    end

endmodule

// File: rtl/dwalk_chk.sv
module dwalk_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_req,
    input logic rd_req,
    input logic rd_vld,
    input logic xfer_start,
    input logic xfer_done,
    input logic busy,
    input logic done,
    input logic abort,
    input logic irq_local,
    input logic irq_remote
);

    logic outst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               outst_q <= 1'b0;
        else if (rd_req)          outst_q <= 1'b1;
        else if (rd_vld || abort) outst_q <= 1'b0;
    end

    // R4
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && outst_q));

    // R12
    done_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && abort));

    // R12
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || abort));

    // R10
    stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && busy) |-> abort);

    // R9
    quiet_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!rd_req && !xfer_start));

    // R2
    launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R8
    irq_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_local || irq_remote) |-> xfer_done);

endmodule

bind dma_desc_walker dwalk_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .rd_req     (rd_req),
    .rd_vld     (rd_vld),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .busy       (busy),
    .done       (done),
    .abort      (abort),
    .irq_local  (irq_local),
    .irq_remote (irq_remote)
);

// File: tb/sim_dma_desc_walker.sv
module sim_dma_desc_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, stop_req = 1'b0;
    logic        cfg_list_mode = 1'b0, cfg_lie_en = 1'b0, cfg_rie_en = 1'b0;
    logic [31:0] cfg_size = '0;
    logic [63:0] cfg_src = '0, cfg_dst = '0, cfg_list_ptr = '0;
    logic        rd_req, rd_vld = 1'b0;
    logic [63:0] rd_addr;
    logic [31:0] rd_data = '0;
    logic        xfer_start, xfer_done = 1'b0, xfer_err = 1'b0;
    logic [31:0] xfer_size;
    logic [63:0] xfer_src, xfer_dst;
    logic        busy, done, abort, irq_local, irq_remote;

    always #5 clk = ~clk;

    dma_desc_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req),
        .cfg_list_mode(cfg_list_mode), .cfg_lie_en(cfg_lie_en), .cfg_rie_en(cfg_rie_en),
        .cfg_size(cfg_size), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_list_ptr(cfg_list_ptr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_vld(rd_vld), .rd_data(rd_data), .xfer_start(xfer_start),
        .xfer_size(xfer_size), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_done(xfer_done), .xfer_err(xfer_err), .busy(busy), .done(done),
        .abort(abort), .irq_local(irq_local), .irq_remote(irq_remote)
    );

    int n_chk = 0, n_bad = 0;

    // Models: memory and transfer engine, driven at the falling edge
    logic [31:0] mem [0:255];
    logic [63:0] rd_log [0:63];
    int          rd_n = 0, overlap = 0, mem_cnt = 0;
    logic [63:0] mem_addr_q = '0;
    logic [31:0] xs_log [0:7];
    logic [63:0] xa_log [0:7], xd_log [0:7];
    int          xlog_n = 0, x_cnt = 0;
    logic        err_mode = 1'b0;

    always @(negedge clk) begin
        rd_vld = 1'b0;
        if (mem_cnt > 0) begin
            mem_cnt = mem_cnt - 1;
            if (mem_cnt == 0) begin
                rd_vld  = 1'b1;
                rd_data = mem[mem_addr_q[9:2]];
            end
        end
        if (rd_req) begin
            if (mem_cnt != 0) overlap = overlap + 1;
            if (rd_n < 64) rd_log[rd_n] = rd_addr;
            rd_n       = rd_n + 1;
            mem_addr_q = rd_addr;
            mem_cnt    = 2;
        end
    end

    always @(negedge clk) begin
        xfer_done = 1'b0;
        xfer_err  = 1'b0;
        if (x_cnt > 0) begin
            x_cnt = x_cnt - 1;
            if (x_cnt == 0) begin
                if (err_mode) xfer_err = 1'b1;
                else          xfer_done = 1'b1;
            end
        end
        if (xfer_start) begin
            if (xlog_n < 8) begin
                xs_log[xlog_n] = xfer_size;
                xa_log[xlog_n] = xfer_src;
                xd_log[xlog_n] = xfer_dst;
            end
            xlog_n = xlog_n + 1;
            x_cnt  = 3;
        end
    end

    // Event monitor
    int done_cnt = 0, abort_cnt = 0, irql_cnt = 0, irqr_cnt = 0, irq_at = -1;
    always @(posedge clk) begin
        if (rst_n) begin
            if (done)       done_cnt  = done_cnt + 1;
            if (abort)      abort_cnt = abort_cnt + 1;
            if (irq_local)  begin irql_cnt = irql_cnt + 1; irq_at = xlog_n; end
            if (irq_remote) irqr_cnt = irqr_cnt + 1;
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        rd_n = 0; overlap = 0; xlog_n = 0;
        done_cnt = 0; abort_cnt = 0; irql_cnt = 0; irqr_cnt = 0; irq_at = -1;
        err_mode = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int n = 0;
        while ((done_cnt + abort_cnt) == 0 && n < 500) begin
            @(negedge clk); n++;
        end
        check(n < 500, req, n, 500);
        repeat (20) @(negedge clk);
        #1;
    endtask

    task automatic put_desc(input int a, input logic [31:0] c, input logic [31:0] s,
                            input logic [63:0] sa, input logic [63:0] da);
        mem[(a >> 2) + 0] = c;
        mem[(a >> 2) + 1] = s;
        mem[(a >> 2) + 2] = sa[31:0];
        mem[(a >> 2) + 3] = sa[63:32];
        mem[(a >> 2) + 4] = da[31:0];
        mem[(a >> 2) + 5] = da[63:32];
    endtask

    task automatic t_reset();
        #1;
        check(!busy && !rd_req && !xfer_start, "R1 idle outputs", {busy, rd_req, xfer_start}, 0);
        check(!done && !abort && !irq_local && !irq_remote, "R1 pulses",
              {done, abort, irq_local, irq_remote}, 0);
    endtask

    task automatic t_direct();
        int n = 0;
        clear_logs();
        cfg_list_mode = 1'b0; cfg_lie_en = 1'b1; cfg_rie_en = 1'b0;
        cfg_size = 32'h100; cfg_src = 64'h1_0000_0040; cfg_dst = 64'h2_0000_0080;
        pulse_start();
        while (xlog_n == 0 && n < 50) begin @(negedge clk); #1; n++; end
        // second start while busy must be ignored (R11)
        start = 1'b1; @(negedge clk); #1 start = 1'b0;
        wait_end("R2 direct finish");
        check(xlog_n == 1, "R2 R11 one transfer", xlog_n, 1);
        check(xs_log[0] == 32'h100, "R2 size", xs_log[0], 32'h100);
        check(xa_log[0] == 64'h1_0000_0040, "R2 src", xa_log[0], 64'h1_0000_0040);
        check(xd_log[0] == 64'h2_0000_0080, "R2 dst", xd_log[0], 64'h2_0000_0080);
        check(rd_n == 0, "R2 no reads", rd_n, 0);
        check(done_cnt == 1 && abort_cnt == 0, "R12 done once", done_cnt, 1);
        check(irql_cnt == 1 && irqr_cnt == 0, "R3 local only", {irql_cnt, irqr_cnt}, 64'h1_00000000);
        check(!busy, "R2 idle after", busy, 0);
    endtask

    task automatic t_direct_remote();
        clear_logs();
        cfg_list_mode = 1'b0; cfg_lie_en = 1'b0; cfg_rie_en = 1'b1;
        cfg_size = 32'h8; cfg_src = 64'h10; cfg_dst = 64'h20;
        pulse_start();
        wait_end("R3 direct remote finish");
        check(irql_cnt == 0 && irqr_cnt == 1, "R3 remote only", {irql_cnt, irqr_cnt}, 1);
    endtask

    task automatic t_list();
        logic [63:0] bases [0:4];
        clear_logs();
        bases[0] = 64'h100; bases[1] = 64'h118; bases[2] = 64'h130;
        bases[3] = 64'h200; bases[4] = 64'h218;
        put_desc(32'h100, 32'h1,  32'h40, 64'h5_0000_1000, 64'h6_0000_2000); // cycle bit set
        put_desc(32'h118, 32'h0,  32'h80, 64'h5_0000_3000, 64'h6_0000_4000);
        put_desc(32'h130, 32'h4,  32'h0,  64'h200,         64'h0);          // link, skip
        put_desc(32'h200, 32'h18, 32'hC0, 64'h7_0000_0000, 64'h8_0000_0000); // both irqs
        put_desc(32'h218, 32'h6,  32'h0,  64'h0,           64'h0);          // terminate
        cfg_list_mode = 1'b1; cfg_lie_en = 1'b1; cfg_rie_en = 1'b1;
        cfg_list_ptr = 64'h100;
        pulse_start();
        wait_end("R7 list finish");
        check(rd_n == 30, "R4 R7 read count", rd_n, 30);
        for (int e = 0; e < 5; e++) begin
            for (int k = 0; k < 6; k++) begin
                if (e * 6 + k < 64)
                    check(rd_log[e*6+k] == bases[e] + 64'(4*k), "R4 R5 R6 read addr",
                          rd_log[e*6+k], bases[e] + 64'(4*k));
            end
        end
        check(overlap == 0, "R4 one outstanding", overlap, 0);
        check(xlog_n == 3, "R6 R7 transfer count", xlog_n, 3);
        check(xs_log[0] == 32'h40 && xa_log[0] == 64'h5_0000_1000 && xd_log[0] == 64'h6_0000_2000,
              "R5 R11 element0", xa_log[0], 64'h5_0000_1000);
        check(xs_log[1] == 32'h80 && xa_log[1] == 64'h5_0000_3000 && xd_log[1] == 64'h6_0000_4000,
              "R5 element1", xa_log[1], 64'h5_0000_3000);
        check(xs_log[2] == 32'hC0 && xa_log[2] == 64'h7_0000_0000 && xd_log[2] == 64'h8_0000_0000,
              "R5 R6 element after link", xa_log[2], 64'h7_0000_0000);
        check(irql_cnt == 1 && irqr_cnt == 1, "R8 element irqs only", {irql_cnt, irqr_cnt},
              64'h1_00000001);
        check(irq_at == 3, "R8 irq on third transfer", irq_at, 3);
        check(done_cnt == 1 && abort_cnt == 0, "R7 R12 done", done_cnt, 1);
        check(!busy, "R7 idle", busy, 0);
    endtask

    task automatic t_error();
        clear_logs();
        put_desc(32'h300, 32'h18, 32'h10, 64'h400, 64'h500);
        put_desc(32'h318, 32'h0,  32'h10, 64'h600, 64'h700);
        err_mode = 1'b1;
        cfg_list_mode = 1'b1; cfg_list_ptr = 64'h300;
        pulse_start();
        wait_end("R9 error finish");
        check(abort_cnt == 1 && done_cnt == 0, "R9 abort not done", abort_cnt, 1);
        check(rd_n == 6, "R9 no further reads", rd_n, 6);
        check(xlog_n == 1, "R9 one transfer", xlog_n, 1);
        check(irql_cnt == 0 && irqr_cnt == 0, "R9 no irq on error", irql_cnt, 0);
        check(!busy, "R9 idle", busy, 0);
        err_mode = 1'b0;
    endtask

    task automatic t_stop();
        int n = 0, snap = 0;
        clear_logs();
        cfg_list_mode = 1'b1; cfg_list_ptr = 64'h100;
        pulse_start();
        while (rd_n < 3 && n < 200) begin @(negedge clk); #1; n++; end
        stop_req = 1'b1;
        @(posedge clk); #1 stop_req = 1'b0;
        snap = rd_n;
        repeat (30) @(negedge clk);
        #1;
        check(abort_cnt == 1 && done_cnt == 0, "R10 abort", abort_cnt, 1);
        check(rd_n == snap, "R10 no reads after stop", rd_n, snap);
        check(xlog_n == 0, "R10 no transfer", xlog_n, 0);
        check(!busy, "R10 idle", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_direct();
        t_direct_remote();
        t_list();
        t_error();
        t_stop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule